// File: doc/BRIEF.md
# Crosspoint Matrix Control Latches

This block holds the routing and output-enable state of a 16-output, 16-input switch matrix. A complete matrix image is first built in a 96-bit staging register. It can be shifted in one bit per clock or written as a whole word. A one-cycle update strobe then copies the image into the active latches. The active latches drive a select code, an enable flag and a gain flag for each output. A separate 16-bit command word reprograms one output directly in the active latches and writes the same field into the staging image.

Reset is asynchronous and can come from three sources: an active-low external pin, a supply-low (power-on) condition and an overtemperature flag. The supply-low source is stretched by a parameterised number of clock cycles after it clears. Reset clears only the enable flags in the active latches. Select and gain fields are kept, and so is the staging image. Outputs stay off after reset until a command word or an update is applied. An update with no reload in between brings back the whole previous configuration.

Top module: `xpt_ctrl_latch`

## Requirements
- R1: With `shift_en_i` high, each rising edge shifts `shift_d_i` into the staging image at bit 0, moving earlier bits toward bit 95. After 96 shifts, the first bit sent sits at bit 95. The field for output n is bits [6n+5:6n]: select in [6n+3:6n], enable at 6n+4, gain at 6n+5.
- R2: `par_load_i` replaces the whole staging image with `par_word_i` at the next edge and takes priority over shifting.
- R3: Loading the staging image leaves the outputs unchanged. A single-cycle `update_i` copies all 96 bits into the active latches at the next edge.
- R4: `cmd_valid_i` with `cmd_i` carrying the output address in [15:12], reserved bits in [11:6] and a 6-bit field in [5:0] writes that field into the addressed output at the next edge. Every other output is left unchanged. The reserved bits have no effect.
- R5: The command word also writes its field into the matching slice of the staging image, so a later update keeps it.
- R6: While any reset source is active, every `en_o` bit is 0, with no clock needed. `sel_o` and `gain_o` keep their values.
- R7: When reset is released, all outputs stay disabled until an update or a command word.
- R8: If the staging image has not been reloaded since reset, one update restores every field of the previous configuration, enables included.
- R9: Reset stays active for `POR_HOLD_CYC` rising edges after `supply_low_i` falls (default 10, 40 ns at 250 MHz). An update inside that window has no effect.
- R10: While reset is active, `update_i` and `cmd_valid_i` are ignored in the active latches and in the staging image. Staging loads still work.
- R11: `overtemp_i` high acts as reset. When it clears, outputs remain disabled until reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | External asynchronous reset, active low |
| supply_low_i | input | 1 | Supply below threshold (power-on reset source), active high |
| overtemp_i | input | 1 | Overtemperature flag, active high |
| shift_en_i | input | 1 | Serial shift enable |
| shift_d_i | input | 1 | Serial data, MSB first |
| par_load_i | input | 1 | Parallel staging load |
| par_word_i | input | 96 | Parallel staging word |
| update_i | input | 1 | Copy staging image into active latches |
| cmd_valid_i | input | 1 | Individual-output command strobe |
| cmd_i | input | 16 | Individual-output command word |
| sel_o | output | 64 | Input select per output, 4 bits each, output n at [4n+3:4n] |
| en_o | output | 16 | Output enable per output |
| gain_o | output | 16 | Gain flag per output |

## Verification
Serial and parallel loads are tried with arithmetic word patterns in which select, enable and gain vary with the output index and a seed. A swapped bit order, a misplaced field or a loss of select/enable/gain separation therefore shows up on some output. The command word is swept over all 16 addresses with several field values and fixed non-zero reserved bits. This separates a correct one-output write from writes that spill over to other outputs or that decode the reserved bits. Reset is applied from each of the three sources with updates and commands issued inside the reset and inside the power-on hold window. This tells a design that clears only the enables apart from one that clears the fields, loses the staging image, or releases reset early.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned N_OUT  = 16;
  localparam int unsigned N_IN   = 16;
  localparam int unsigned SEL_W  = $clog2(N_IN);
  localparam int unsigned FLD_W  = SEL_W + 2;          // sel, en, gain
  localparam int unsigned WORD_W = N_OUT * FLD_W;
  localparam int unsigned ADDR_W = $clog2(N_OUT);
  localparam int unsigned CMD_W  = 16;
  localparam int unsigned EN_BIT = SEL_W;
  localparam int unsigned GN_BIT = SEL_W + 1;

  typedef struct packed {
    logic             gain;
    logic             en;
    logic [SEL_W-1:0] sel;
  } fld_t;
endpackage

// File: rtl/xpt_rst_gen.sv
module xpt_rst_gen #(
  parameter int unsigned HOLD_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic overtemp_i,
  output logic rst_n_o,   // async reset for enable flops
  output logic run_o      // same condition, for gating clocked writes
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 2);

  logic [CW-1:0] cnt_q;
  logic          hold_done;

  always_ff @(posedge clk_i or posedge supply_low_i) begin
    if (supply_low_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign hold_done = (cnt_q == CW'(HOLD_CYC));
  assign rst_n_o   = rst_ni & ~supply_low_i & ~overtemp_i & hold_done;
  assign run_o     = rst_ni & ~supply_low_i & ~overtemp_i & hold_done;
endmodule

// File: rtl/xpt_stage_reg.sv
module xpt_stage_reg
  import xpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              shift_en_i,
  input  logic              shift_d_i,
  input  logic              par_load_i,
  input  logic [WORD_W-1:0] par_word_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  fld_t              wr_fld_i,
  output logic [WORD_W-1:0] stage_o
);
  logic [WORD_W-1:0] stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (par_load_i)      stage_d = par_word_i;
    else if (shift_en_i) stage_d = {stage_q[WORD_W-2:0], shift_d_i};
    for (int i = 0; i < int'(N_OUT); i++) begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(i)))
        stage_d[i*FLD_W +: FLD_W] = wr_fld_i;
    end
  end

  // staging image is never reset
  always_ff @(posedge clk_i) stage_q <= stage_d;

  assign stage_o = stage_q;
endmodule

// File: rtl/xpt_active_latch.sv
module xpt_active_latch
  import xpt_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_n_i,
  input  logic                   run_i,
  input  logic                   update_i,
  input  logic [WORD_W-1:0]      stage_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  fld_t                   wr_fld_i,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o,
  output logic [N_OUT-1:0]       gain_o
);
  for (genvar g = 0; g < int'(N_OUT); g++) begin : g_out
    logic             hit;
    fld_t             src;
    logic             en_q;
    logic             gain_q;
    logic [SEL_W-1:0] sel_q;

    assign hit = run_i & wr_en_i & (wr_addr_i == ADDR_W'(g));
    assign src = hit ? wr_fld_i : fld_t'(stage_i[g*FLD_W +: FLD_W]);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                       en_q <= 1'b0;
      else if (hit || (run_i && update_i)) en_q <= src.en;
    end

    // routing and gain survive reset
    always_ff @(posedge clk_i) begin
      if (hit || (run_i && update_i)) begin
        sel_q  <= src.sel;
        gain_q <= src.gain;
      end
    end

    assign en_o[g]                 = en_q;
    assign gain_o[g]               = gain_q;
    assign sel_o[g*SEL_W +: SEL_W] = sel_q;
  end
endmodule

// File: rtl/xpt_ctrl_latch.sv
module xpt_ctrl_latch
  import xpt_pkg::*;
#(
  parameter int unsigned POR_HOLD_CYC = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   supply_low_i,
  input  logic                   overtemp_i,
  input  logic                   shift_en_i,
  input  logic                   shift_d_i,
  input  logic                   par_load_i,
  input  logic [WORD_W-1:0]      par_word_i,
  input  logic                   update_i,
  input  logic                   cmd_valid_i,
  input  logic [CMD_W-1:0]       cmd_i,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       en_o,
  output logic [N_OUT-1:0]       gain_o
);
  logic              rst_n_int;
  logic              run;
  logic [WORD_W-1:0] stage;
  logic [ADDR_W-1:0] cmd_addr;
  fld_t              cmd_fld;
  logic              cmd_wr;

  assign cmd_addr = cmd_i[CMD_W-1 -: ADDR_W];
  assign cmd_fld  = fld_t'(cmd_i[FLD_W-1:0]);
  assign cmd_wr   = cmd_valid_i & run;

  xpt_rst_gen #(.HOLD_CYC(POR_HOLD_CYC)) rst_gen_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .supply_low_i (supply_low_i),
    .overtemp_i   (overtemp_i),
    .rst_n_o      (rst_n_int),
    .run_o        (run)
  );

  xpt_stage_reg stage_i (
    .clk_i      (clk_i),
    .shift_en_i (shift_en_i),
    .shift_d_i  (shift_d_i),
    .par_load_i (par_load_i),
    .par_word_i (par_word_i),
    .wr_en_i    (cmd_wr),
    .wr_addr_i  (cmd_addr),
    .wr_fld_i   (cmd_fld),
    .stage_o    (stage)
  );

  xpt_active_latch act_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_int),
    .run_i     (run),
    .update_i  (update_i),
    .stage_i   (stage),
    .wr_en_i   (cmd_valid_i),
    .wr_addr_i (cmd_addr),
    .wr_fld_i  (cmd_fld),
    .sel_o     (sel_o),
    .en_o      (en_o),
    .gain_o    (gain_o)
  );
endmodule

// File: rtl/xpt_ctrl_latch_chk.sv
module xpt_ctrl_latch_chk
  import xpt_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   supply_low_i,
  input logic                   overtemp_i,
  input logic                   rst_n_int,
  input logic                   update_i,
  input logic                   cmd_valid_i,
  input logic [CMD_W-1:0]       cmd_i,
  input logic [N_OUT*SEL_W-1:0] sel_o,
  input logic [N_OUT-1:0]       en_o
);
  // R6
  en_clear_in_reset_chk: assert property (@(posedge clk_i)
    !rst_n_int |-> (en_o == '0));

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(update_i) && !$past(cmd_valid_i)) |-> $stable(sel_o));

  // R7
  en_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o & ~$past(en_o)) != '0) |-> $past(rst_n_int && (update_i || cmd_valid_i)));

  // R4
  cmd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $past(cmd_valid_i && rst_n_int) |->
      (sel_o[$past(cmd_i[CMD_W-1 -: ADDR_W])*SEL_W +: SEL_W] == $past(cmd_i[SEL_W-1:0])) &&
      (en_o[$past(cmd_i[CMD_W-1 -: ADDR_W])] == $past(cmd_i[EN_BIT])));

  // R9
  por_hold_chk: assert property (@(posedge clk_i)
    supply_low_i |=> !rst_n_int);

  // R11
  overtemp_rst_chk: assert property (@(posedge clk_i)
    overtemp_i |-> !rst_n_int);
endmodule

bind xpt_ctrl_latch xpt_ctrl_latch_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supply_low_i (supply_low_i),
  .overtemp_i   (overtemp_i),
  .rst_n_int    (rst_n_int),
  .update_i     (update_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .sel_o        (sel_o),
  .en_o         (en_o)
);

// File: tb/xpt_ctrl_latch_tb_top.sv
module xpt_ctrl_latch_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1, supply_low_i = 1'b1, overtemp_i = 1'b0;
  logic        shift_en_i = 1'b0, shift_d_i = 1'b0, par_load_i = 1'b0;
  logic [95:0] par_word_i = '0;
  logic        update_i = 1'b0, cmd_valid_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic [63:0] sel_o;
  logic [15:0] en_o, gain_o;

  int checks = 0, fails = 0;
  logic [95:0] exp_act = '0, exp_stage = '0, saved;
  bit rst_on = 1'b1;

  always #2 clk_i = ~clk_i;

  xpt_ctrl_latch #(.POR_HOLD_CYC(10)) dut_i (.*);

  function automatic logic [95:0] mk_word(int s);
    logic [95:0] w;
    for (int n = 0; n < 16; n++) begin
      w[6*n +: 4] = 4'((n * s + 3) % 16);
      w[6*n + 4]  = ((n + s) % 3) != 0;
      w[6*n + 5]  = ((n ^ s) & 1) != 0;
    end
    return w;
  endfunction

  function automatic logic [95:0] got_word();
    logic [95:0] g;
    for (int n = 0; n < 16; n++) g[6*n +: 6] = {gain_o[n], en_o[n], sel_o[4*n +: 4]};
    return g;
  endfunction

  function automatic logic [95:0] no_en(logic [95:0] w);
    for (int n = 0; n < 16; n++) w[6*n + 4] = 1'b0;
    return w;
  endfunction

  task automatic chk_act(string r);
    logic [95:0] g = got_word();
    checks++;
    if (g !== exp_act) begin
      fails++;
      $display("FAIL %s got %h exp %h", r, g, exp_act);
    end
  endtask

  task automatic chk_en_off(string r);
    checks++;
    if (en_o !== 16'h0) begin
      fails++;
      $display("FAIL %s en got %h exp 0000", r, en_o);
    end
  endtask

  task automatic pulse_update();
    update_i = 1'b1;
    @(negedge clk_i);
    update_i = 1'b0;
    if (!rst_on) exp_act = exp_stage;
  endtask

  task automatic send_cmd(logic [3:0] a, logic [5:0] f);
    cmd_i = {a, 6'h2A, f};
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    if (!rst_on) begin
      exp_act[6*a +: 6]   = f;
      exp_stage[6*a +: 6] = f;
    end
  endtask

  task automatic par_load(logic [95:0] w);
    par_word_i = w;
    par_load_i = 1'b1;
    @(negedge clk_i);
    par_load_i = 1'b0;
    exp_stage = w;
  endtask

  task automatic shift_word(logic [95:0] w);
    for (int i = 95; i >= 0; i--) begin
      shift_d_i = w[i];
      shift_en_i = 1'b1;
      @(negedge clk_i);
    end
    shift_en_i = 1'b0;
    exp_stage = w;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk_en_off("R6 reset state");
    par_load(mk_word(2));                  // R10: staging loads in reset
    supply_low_i = 1'b0;
    repeat (2) @(negedge clk_i);
    pulse_update();                        // R9: inside hold window
    chk_en_off("R9 update in hold");
    repeat (12) @(negedge clk_i);
    rst_on = 1'b0;
    chk_en_off("R7 after release");
    pulse_update();
    chk_act("R2 R9 update after hold");

    // R1/R3 serial sweep
    for (int s = 1; s <= 6; s++) begin
      saved = exp_act;
      shift_word(mk_word(s * 5 + 1));
      chk_act("R3 shift no update");
      pulse_update();
      chk_act("R1 serial word");
    end
    // R2 parallel sweep
    for (int s = 7; s <= 12; s++) begin
      par_load(mk_word(s));
      chk_act("R3 load no update");
      pulse_update();
      chk_act("R2 parallel word");
    end

    // R4/R5 one output, then update
    par_load(mk_word(21));
    send_cmd(4'd3, 6'h1B);
    chk_act("R4 single cmd");
    pulse_update();
    chk_act("R5 cmd kept in staging");

    // R4 address sweep
    for (int a = 0; a < 16; a++) begin
      for (int f = 0; f < 4; f++) begin
        send_cmd(4'(a), 6'((a * 7 + f * 19) % 64));
        chk_act("R4 cmd sweep");
      end
    end
    pulse_update();
    chk_act("R5 update after sweep");

    // R6/R10/R8 external reset
    par_load(mk_word(33));
    pulse_update();
    saved = exp_act;
    rst_ni = 1'b0; rst_on = 1'b1;
    #1;
    exp_act = no_en(saved);
    chk_act("R6 async clear keeps fields");
    @(negedge clk_i);
    pulse_update();
    send_cmd(4'd7, 6'h3F);
    chk_act("R10 writes ignored in reset");
    rst_ni = 1'b1; rst_on = 1'b0;
    repeat (2) @(negedge clk_i);
    chk_act("R7 still disabled");
    pulse_update();
    exp_act = saved;
    chk_act("R8 restore all");

    // R11 overtemp
    overtemp_i = 1'b1; rst_on = 1'b1;
    @(negedge clk_i);
    exp_act = no_en(saved);
    chk_act("R11 overtemp clears en");
    overtemp_i = 1'b0; rst_on = 1'b0;
    @(negedge clk_i);
    chk_act("R11 disabled after clear");
    send_cmd(4'd5, 6'h19);
    chk_act("R7 cmd enables one");
    pulse_update();
    chk_act("R5 R8 restore with cmd slice");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule